// File: doc/BRIEF.md
# Six-Step Commutation and PWM Gating

This block turns three digitised rotor-position bits into the six gate enables of a three-phase bridge: one high-side and one low-side enable per phase. A direction input selects the forward or the reversed commutation order. A free-running sawtooth counter is compared with a duty command to chop the drive. The chopping is applied to the high-side enables only, and the low-side enable stays steady for a whole commutation step.

The high side is further gated by several inputs: an active-low external PWM pulse, an undervoltage flag, a stall-protection drive enable and a current-limit flag. The current-limit flag cuts the rest of the present PWM cycle. A stop request, an illegal position code, or the single clock that follows each step change turns all six enables off. Analog sensing, hysteresis on the flags and the power stage are outside the block.

Top module: `sixstep_pwm_gate`

## Requirements
- R1: In forward direction (`dir_rev`=0), with `hall` written as bits [2:1:0], the pairs are: 101 gives U high with V low, 100 gives U high with W low, 110 gives V high with W low, 010 gives V high with U low, 011 gives W high with U low, and 001 gives W high with V low. In both gate buses, bit 0 is U, bit 1 is V and bit 2 is W. No phase ever has its high and low enables on together.
- R2: In reverse direction (`dir_rev`=1), the high-side phase and the low-side phase of each code are swapped relative to R1.
- R3: A `hall` code of 000 or 111 drives all six enables low, and so does the reset state.
- R4: `pwm_in_n` is active-low. When it is 1, all high-side enables are off. When it is 0, it leaves the drive on. It never affects the low side.
- R5: `stop_req`=1 turns all six enables off. `stop_req`=0 is run mode.
- R6: The PWM period is SPAN = DUTY_HI - DUTY_LO clocks (85 by default). In each period the high side is on for 0 clocks when `duty` <= DUTY_LO, for every clock when `duty` >= DUTY_HI, and for `duty` - DUTY_LO clocks in between.
- R7: `uv_flag`=1 turns the high-side enables off and leaves the low side on.
- R8: `ilim_flag` turns the high side off at once. The cut lasts until the PWM counter next wraps, even if the flag drops earlier.
- R9: After the registered position code changes, all enables are off for exactly one clock. The new pair is driven from the following clock.
- R10: `stall_drive_en`=0 turns the high-side enables off and leaves the low side on.
- R11: The low-side enable is not chopped by the PWM. It stays on for every clock of a step, at any duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hall | input | 3 | Digitised position sensors, bit 2 first in code notation |
| dir_rev | input | 1 | 1 selects the reversed commutation order |
| stop_req | input | 1 | 1 = stop, all enables off |
| pwm_in_n | input | 1 | External PWM, 0 = drive on |
| uv_flag | input | 1 | Undervoltage present |
| ilim_flag | input | 1 | Current limit reached |
| stall_drive_en | input | 1 | Stall-protection drive window, 1 = allowed |
| duty | input | CNT_W | Duty command code |
| gate_hi | output | 3 | High-side enables {W,V,U} |
| gate_lo | output | 3 | Low-side enables {W,V,U} |

## Verification
The embedded properties watch several behaviours on every clock: the one-hot shape of each bus and the absence of shoot-through, all-off on an illegal code or a stop, and high-side suppression under the external pulse, undervoltage and current-limit inputs. They also watch the blanking clock after each step change and the steadiness of the low side within a step. Only the bench scenarios can show the exact decode pairs in both directions and the number of on-clocks per period for each duty code. They alone also measure that a current-limit pulse keeps the high side off for precisely the remainder of its period.

// File: rtl/sixstep_pwm_gate.sv
module sixstep_pwm_gate #(
  parameter int CNT_W   = 8,
  parameter int DUTY_LO = 69,
  parameter int DUTY_HI = 154
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       hall,
  input  logic             dir_rev,
  input  logic             stop_req,
  input  logic             pwm_in_n,
  input  logic             uv_flag,
  input  logic             ilim_flag,
  input  logic             stall_drive_en,
  input  logic [CNT_W-1:0] duty,
  output logic [2:0]       gate_hi,
  output logic [2:0]       gate_lo
);
  localparam int SPAN = DUTY_HI - DUTY_LO;
  localparam int PW   = $clog2(SPAN);

  logic [2:0]    hall_q;
  logic          blank_q;
  logic          ilim_q;
  logic [PW-1:0] cnt;
  logic          wrap;
  logic [2:0]    fwd_hi, fwd_lo;
  logic          illegal, pwm_on, hi_en;

  assign wrap = (cnt == PW'(SPAN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hall_q  <= 3'b000;
      blank_q <= 1'b1;
      ilim_q  <= 1'b0;
      cnt     <= '0;
    end else begin
      hall_q  <= hall;
      blank_q <= (hall != hall_q);
      ilim_q  <= wrap ? 1'b0 : (ilim_q | ilim_flag);
      cnt     <= wrap ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    case (hall_q)
      3'b101:  begin fwd_hi = 3'b001; fwd_lo = 3'b010; end
      3'b100:  begin fwd_hi = 3'b001; fwd_lo = 3'b100; end
      3'b110:  begin fwd_hi = 3'b010; fwd_lo = 3'b100; end
      3'b010:  begin fwd_hi = 3'b010; fwd_lo = 3'b001; end
      3'b011:  begin fwd_hi = 3'b100; fwd_lo = 3'b001; end
      3'b001:  begin fwd_hi = 3'b100; fwd_lo = 3'b010; end
      default: begin fwd_hi = 3'b000; fwd_lo = 3'b000; end
    endcase
  end

  assign illegal = (hall_q == 3'b000) || (hall_q == 3'b111);
  assign pwm_on  = (duty >= CNT_W'(DUTY_HI)) ||
                   ((duty > CNT_W'(DUTY_LO)) && ((duty - CNT_W'(DUTY_LO)) > CNT_W'(cnt)));
  assign hi_en   = pwm_on && !pwm_in_n && !uv_flag && stall_drive_en && !ilim_q && !ilim_flag;

  logic allow;
  assign allow   = !stop_req && !illegal && !blank_q;
  assign gate_hi = (allow && hi_en) ? (dir_rev ? fwd_lo : fwd_hi) : 3'b000;
  assign gate_lo = allow ? (dir_rev ? fwd_hi : fwd_lo) : 3'b000;

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_hi) && $onehot0(gate_lo) && ((gate_hi & gate_lo) == 3'b000));
  p_illegal_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_q == 3'b000 || hall_q == 3'b111) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));
  p_extpwm_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_in_n |-> (gate_hi == 3'b000));
  p_stop_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> (gate_hi == 3'b000 && gate_lo == 3'b000));
  p_uv_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> (gate_hi == 3'b000));
  p_ilim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ilim_flag) && cnt != '0) |-> (gate_hi == 3'b000));
  p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_q != $past(hall_q)) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));
  p_stall_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_drive_en |-> (gate_hi == 3'b000));
  p_lo_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_q && $past(!blank_q) && $stable(hall_q) && $stable(stop_req) && $stable(dir_rev))
      |-> $stable(gate_lo));
endmodule

// File: tb/tb_sixstep_pwm_gate.sv
`timescale 1ns/1ps
module tb_sixstep_pwm_gate;
  localparam int CNT_W = 8, LO = 69, HI = 154, SPAN = HI - LO;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic dir_rev = 1'b0, stop_req = 1'b0, pwm_in_n = 1'b0, uv_flag = 1'b0;
  logic ilim_flag = 1'b0, stall_drive_en = 1'b1;
  logic [CNT_W-1:0] duty = 8'd255;
  logic [2:0] gate_hi, gate_lo;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sixstep_pwm_gate #(.CNT_W(CNT_W), .DUTY_LO(LO), .DUTY_HI(HI)) dut (
    .clk(clk), .rst_n(rst_n), .hall(hall), .dir_rev(dir_rev), .stop_req(stop_req),
    .pwm_in_n(pwm_in_n), .uv_flag(uv_flag), .ilim_flag(ilim_flag),
    .stall_drive_en(stall_drive_en), .duty(duty), .gate_hi(gate_hi), .gate_lo(gate_lo));

  // {dir_rev, hall, expected gate_hi, expected gate_lo}
  localparam logic [9:0] VEC [0:15] = '{
    {1'b0,3'b101,3'b001,3'b010}, {1'b0,3'b100,3'b001,3'b100},
    {1'b0,3'b110,3'b010,3'b100}, {1'b0,3'b010,3'b010,3'b001},
    {1'b0,3'b011,3'b100,3'b001}, {1'b0,3'b001,3'b100,3'b010},
    {1'b0,3'b000,3'b000,3'b000}, {1'b0,3'b111,3'b000,3'b000},
    {1'b1,3'b101,3'b010,3'b001}, {1'b1,3'b100,3'b100,3'b001},
    {1'b1,3'b110,3'b100,3'b010}, {1'b1,3'b010,3'b001,3'b010},
    {1'b1,3'b011,3'b001,3'b100}, {1'b1,3'b001,3'b010,3'b100},
    {1'b1,3'b000,3'b000,3'b000}, {1'b1,3'b111,3'b000,3'b000}};

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_hall(input logic [2:0] h);
    @(negedge clk) hall = h;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic count_hi(input logic [CNT_W-1:0] d, output int n);
    @(negedge clk) duty = d;
    n = 0;
    for (int i = 0; i < SPAN; i++) begin
      @(posedge clk); #1;
      if (gate_hi != 3'b000) n++;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    hall = 3'b101;
    repeat (3) @(posedge clk); #1;
    chk("R3 reset", {gate_hi, gate_lo}, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      @(negedge clk) dir_rev = VEC[i][9];
      set_hall(VEC[i][8:6]);
      chk(VEC[i][9] ? "R2 reverse decode" : "R1/R3 forward decode", gate_hi, int'(VEC[i][5:3]));
      chk(VEC[i][9] ? "R2 reverse decode" : "R1/R3 forward decode", gate_lo, int'(VEC[i][2:0]));
    end

    @(negedge clk) dir_rev = 1'b0;
    set_hall(3'b101);
    @(negedge clk) hall = 3'b100;
    @(posedge clk); #1;
    chk("R9 blank clock", {gate_hi, gate_lo}, 0);
    @(posedge clk); #1;
    chk("R9 after blank", {gate_hi, gate_lo}, {3'b001, 3'b100});

    @(negedge clk) stop_req = 1'b1; #1;
    chk("R5 stop", {gate_hi, gate_lo}, 0);
    @(negedge clk) stop_req = 1'b0; pwm_in_n = 1'b1; #1;
    chk("R4 ext pwm high", {gate_hi, gate_lo}, {3'b000, 3'b100});
    @(negedge clk) pwm_in_n = 1'b0; #1;
    chk("R4 ext pwm low", {gate_hi, gate_lo}, {3'b001, 3'b100});
    @(negedge clk) uv_flag = 1'b1; #1;
    chk("R7 undervoltage", {gate_hi, gate_lo}, {3'b000, 3'b100});
    @(negedge clk) uv_flag = 1'b0; stall_drive_en = 1'b0; #1;
    chk("R10 stall off", {gate_hi, gate_lo}, {3'b000, 3'b100});
    @(negedge clk) stall_drive_en = 1'b1;

    count_hi(8'd0, n);        chk("R6 duty 0", n, 0);
    count_hi(8'(LO), n);      chk("R6 duty at low threshold", n, 0);
    count_hi(8'(LO + 1), n);  chk("R6 duty low+1", n, 1);
    count_hi(8'(LO + 40), n); chk("R6 duty mid", n, 40);
    count_hi(8'(HI), n);      chk("R6 duty at high threshold", n, SPAN);
    count_hi(8'(HI - 1), n);  chk("R6 duty high-1", n, SPAN - 1);

    @(negedge clk) duty = 8'(LO + 20);
    n = 0;
    for (int i = 0; i < SPAN; i++) begin
      @(posedge clk); #1;
      if (gate_lo == 3'b100) n++;
    end
    chk("R11 low side unchopped", n, SPAN);

    // find counter phase 0 with a one-clock pulse
    @(negedge clk) duty = 8'(LO + 1);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (gate_hi == 3'b000 && n < 4 * SPAN);
    @(negedge clk) duty = 8'(HI); ilim_flag = 1'b1; #1;
    chk("R8 limit cuts at once", gate_hi, 0);
    @(negedge clk) ilim_flag = 1'b0; #1;
    chk("R8 cut held after flag drops", gate_hi, 0);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (gate_hi == 3'b000 && n < 4 * SPAN);
    chk("R8 release at wrap", n, SPAN - 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule